// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial memory. SCL and SDA are sampled with the system clock. The block finds start and stop conditions on the bus and decodes the device select byte. It then serves writes and reads on an internal byte array. Acknowledge and read data go back through an active-high pull-low enable, which is the open-drain output of the block.

Write data is held in a one-page buffer. It is copied into the array when the master sends a stop. That stop also starts an internal write cycle, which is timed by a counter of system clocks. While the cycle runs, the block raises a busy flag and takes no notice of the bus. A master can poll for the end of the cycle by sending select bytes until one is acknowledged.

The array holds `2**ADDR_W` bytes. Bits above address bit 7 come from the select byte. The select bits that are not needed for the address are compared with the chip-enable pins.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Outside a transfer that began with a start, the block never pulls SDA low. After reset the pull-low enable and the busy flag are both 0.
- R2: Bus bits are taken on SCL rising edges, MSB first. The select byte is laid out as bits[7:4] = type, which must be 1010b, then bits[3:1] = chip-enable/address field, then bit[0] = direction (1 read, 0 write). A matching select is acknowledged by pulling SDA low on the 9th clock. A wrong type gets no acknowledge.
- R3: Let H = ADDR_W-8. Select bits [H:1] supply address bits [ADDR_W-1:8]. The remaining select bits [3:H+1] must equal ce_i[2:H]. With the default ADDR_W=9, bit[1] is address bit 8 and bits[3:2] are compared with ce_i[2:1]. On a mismatch there is no acknowledge, and the block stays idle until the next start.
- R4: A write is a write-select, then the address low byte, then data bytes. Each data byte is acknowledged. Each data byte goes to the current address, and the address then advances only in its low 4 bits, so writes wrap inside a 16-byte page.
- R5: A stop that follows at least one accepted data byte commits the page and holds busy_o high for WRITE_CYCLES clocks. While busy_o is high, starts are ignored, so no select is acknowledged. A stop with no accepted data byte leaves busy_o low.
- R6: A random read is a write-select, then an address byte, then a repeated start with a read-select. It returns the byte at that address, driven MSB first.
- R7: A read-select alone returns the byte at the current counter. The upper address bits of that counter are taken from the select byte. The counter is one past the last byte accessed.
- R8: A read continues while the master acknowledges each byte. The address increments by one after each byte and wraps from the last array byte to 0.
- R9: After a master no-acknowledge, the block releases SDA and drives nothing more until the next start.
- R10: While wp_i is high, write data bytes are not acknowledged and the array is unchanged. Select and address bytes are still acknowledged.
- R11: The pull-low enable is asserted only after an SCL falling edge has been detected, so SDA stays steady while SCL is high.
- R12: A repeated start after write data, with no stop between, discards the buffered data. No write cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire (wired-AND value) |
| ce_i | input | 3 | Chip-enable pins, compared with the select bits that are not used for address |
| wp_i | input | 1 | Write protect, active high |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The bench targets the page wrap: 20 bytes written from offset 10 of a page must wrap inside that page. A design that carried into the page bits would write bytes into the next page. Sequential reads across the top of the array must come back at address 0. The chip-enable comparison and the address bit must use different select bits, or the wrong device answers. The bench also covers polling during the write cycle, where an early acknowledge would let the master talk to a device that is still busy. It covers a protected write that must leave the array unchanged and must not raise busy. A repeated start after write data must not commit the buffered bytes. Finally, the bench checks that the block falls silent after a master no-acknowledge, which a design that kept shifting data out would break.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WR,
    ST_RD
  } ee_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync_q, scl_sync_n, sda_sync_q, sda_sync_n;
  logic scl_prev_q, sda_prev_q, scl_s, sda_s;

  assign scl_s = scl_sync_q[SYNC_STAGES-1];
  assign sda_s = sda_sync_q[SYNC_STAGES-1];

  always_comb begin
    scl_sync_n = {scl_sync_q[SYNC_STAGES-2:0], scl_i};
    sda_sync_n = {sda_sync_q[SYNC_STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= scl_sync_n;
      sda_sync_q <= sda_sync_n;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/eeprom_addr_ctr.sv
module eeprom_addr_ctr #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_hi_i,
  input  logic [2:0]        hi_i,
  input  logic              ld_lo_i,
  input  logic [7:0]        lo_i,
  input  logic              inc_page_i,
  input  logic              inc_seq_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_q, addr_n, hi_val;

  generate
    if (HI_W > 0) begin : g_hi
      assign hi_val = {hi_i[HI_W-1:0], addr_q[7:0]};
    end else begin : g_nohi
      assign hi_val = addr_q;
    end
  endgenerate

  always_comb begin
    addr_n = addr_q;
    if (ld_hi_i)         addr_n = hi_val;
    else if (ld_lo_i)    addr_n[7:0] = lo_i;
    else if (inc_page_i) addr_n[PG_W-1:0] = addr_q[PG_W-1:0] + 1'b1;
    else if (inc_seq_i)  addr_n = addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_n;
  end

  assign addr_o = addr_q;

  // R4: a page step never touches the page number
  assert_page_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_page_i && !ld_hi_i && !ld_lo_i) |=> $stable(addr_q[ADDR_W-1:PG_W]));
  // R8: sequential step past the top lands on zero
  assert_seq_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_seq_i && !ld_hi_i && !ld_lo_i && !inc_page_i && (&addr_q)) |=> (addr_q == '0));
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (go_i)             cnt_n = CNT_W'(CYCLES);
    else if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  assign busy_o = (cnt_q != '0);

  // R5: the controller never relaunches a cycle that is still running
  assert_no_retrigger_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (cnt_q == '0));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] ce_i,
  input  logic       wp_i,
  output logic       sda_oe_o,
  output logic       busy_o
);
  localparam int MEM_BYTES = 2 ** ADDR_W;
  localparam int PG_W      = $clog2(PAGE_BYTES);
  localparam int HI_W      = ADDR_W - 8;
  localparam logic [2:0] CE_MASK = 3'b111 << HI_W;

  ee_state_e st_q, st_n;
  logic [3:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n, tx_q, tx_n;
  logic oe_q, oe_n, mack_q, mack_n;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det, busy;
  logic ld_hi, ld_lo, inc_page, inc_seq, buf_we, vclr, commit, sel_ok;
  logic [ADDR_W-1:0] addr;
  logic [7:0] mem_q [MEM_BYTES];
  logic [7:0] wbuf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] wvalid_q;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i, .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det));

  eeprom_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctr (
    .clk_i, .rst_ni, .ld_hi_i(ld_hi), .hi_i(sh_q[3:1]), .ld_lo_i(ld_lo), .lo_i(sh_q),
    .inc_page_i(inc_page), .inc_seq_i(inc_seq), .addr_o(addr));

  eeprom_wr_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .go_i(commit), .busy_o(busy));

  assign sel_ok = (sh_q[7:4] == DEV_TYPE) && (((sh_q[3:1] ^ ce_i) & CE_MASK) == 3'b000);

  always_comb begin
    st_n = st_q; bit_n = bit_q; sh_n = sh_q; tx_n = tx_q; oe_n = oe_q; mack_n = mack_q;
    ld_hi = 1'b0; ld_lo = 1'b0; inc_page = 1'b0; inc_seq = 1'b0;
    buf_we = 1'b0; vclr = 1'b0; commit = 1'b0;
    if (stop_det) begin
      commit = (st_q == ST_WR) && (wvalid_q != '0);
      st_n = ST_IDLE; oe_n = 1'b0; vclr = 1'b1;
    end else if (start_det && !busy) begin
      st_n = ST_SEL; bit_n = 4'd0; oe_n = 1'b0; vclr = 1'b1;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_q < 4'd8 && st_q != ST_RD) sh_n = {sh_q[6:0], sda_s};
        if (bit_q == 4'd8 && st_q == ST_RD) mack_n = ~sda_s;
        bit_n = bit_q + 4'd1;
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          unique case (st_q)
            ST_SEL: begin
              if (sel_ok) begin oe_n = 1'b1; ld_hi = 1'b1; end
              else st_n = ST_IDLE;
            end
            ST_ADDR: begin oe_n = 1'b1; ld_lo = 1'b1; end
            ST_WR: if (!wp_i) begin oe_n = 1'b1; buf_we = 1'b1; inc_page = 1'b1; end
            default: begin oe_n = 1'b0; inc_seq = 1'b1; end
          endcase
        end else if (bit_q == 4'd9) begin
          bit_n = 4'd0; oe_n = 1'b0;
          unique case (st_q)
            ST_SEL: begin
              if (sh_q[0]) begin st_n = ST_RD; tx_n = mem_q[addr]; oe_n = ~mem_q[addr][7]; end
              else st_n = ST_ADDR;
            end
            ST_ADDR: st_n = ST_WR;
            ST_RD: begin
              if (mack_q) begin tx_n = mem_q[addr]; oe_n = ~mem_q[addr][7]; end
              else st_n = ST_IDLE;
            end
            default: st_n = st_q;
          endcase
        end else if (st_q == ST_RD) begin
          oe_n = ~tx_q[3'd7 - bit_q[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; bit_q <= '0; sh_q <= '0; tx_q <= '0;
      oe_q <= 1'b0; mack_q <= 1'b0; wvalid_q <= '0;
    end else begin
      st_q <= st_n; bit_q <= bit_n; sh_q <= sh_n; tx_q <= tx_n;
      oe_q <= oe_n; mack_q <= mack_n;
      if (vclr)        wvalid_q <= '0;
      else if (buf_we) wvalid_q[addr[PG_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (buf_we) wbuf_q[addr[PG_W-1:0]] <= sh_q;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (commit && wvalid_q[i]) mem_q[{addr[ADDR_W-1:PG_W], PG_W'(i)}] <= wbuf_q[i];
    end
  end

  assign sda_oe_o = oe_q;
  assign busy_o   = busy;

  // R11: pull-low only begins right after a detected SCL fall
  assert_oe_after_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && !$past(oe_q)) |-> $past(scl_fall));
  // R10: no data acknowledge while protected
  assert_wp_no_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR && oe_q && !$past(oe_q)) |-> !$past(wp_i));
  // R5: silent while the write cycle runs
  assert_busy_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !oe_q);
  // R9: idle means released
  assert_idle_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !oe_q);
endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
  localparam int AW = 9;
  localparam int MB = 512;
  localparam int WC = 400;
  localparam int Q  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] ce = 3'b101;
  wire sda_oe, busy;
  wire sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_eeprom_slave #(.ADDR_W(AW), .WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .ce_i(ce),
    .wp_i(wp), .sda_oe_o(sda_oe), .busy_o(busy));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] ref_m [MB];
  bit known [MB];
  logic [7:0] wdat [32];
  logic [7:0] rdat [32];

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [7:0] sel_byte(bit rw, bit a8);
    return {4'b1010, 2'b10, a8, rw};
  endfunction

  function automatic int page_addr(int base, int k);
    return (base & ~15) | ((base + k) & 15);
  endfunction

  function automatic int seq_addr(int base, int k);
    return (base + k) % MB;
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = d[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); acked = ~sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d, output bit stab);
    logic s0, s1;
    stab = 1'b1; sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(1); s0 = sda_bus; tick(Q); d[i] = sda_bus;
      tick(Q - 1); s1 = sda_bus; scl_m = 1'b0;
      if (s0 != d[i] || s1 != d[i]) stab = 1'b0;
    end
    tick(Q); sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(int a, int n, output bit data_ack);
    bit ak;
    data_ack = 1'b1;
    i2c_start(); send_byte(sel_byte(1'b0, a[8]), ak); send_byte(a[7:0], ak);
    for (int k = 0; k < n; k++) begin
      send_byte(wdat[k], ak);
      data_ack &= ak;
      if (!wp) begin ref_m[page_addr(a, k)] = wdat[k]; known[page_addr(a, k)] = 1'b1; end
    end
    i2c_stop();
  endtask

  task automatic rand_read(int a, int n, output bit stab, output bit sel_ack);
    bit ak, s;
    stab = 1'b1;
    i2c_start(); send_byte(sel_byte(1'b0, a[8]), ak); send_byte(a[7:0], ak);
    i2c_start(); send_byte(sel_byte(1'b1, a[8]), sel_ack);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, rdat[k], s);
      stab &= s;
    end
    i2c_stop();
  endtask

  task automatic wait_ready();
    bit ak;
    tick(WC + 20);
    chk(busy == 1'b0, "R5", "busy after cycle", busy, 0);
    i2c_start(); send_byte(sel_byte(1'b0, 1'b0), ak); i2c_stop();
    chk(ak, "R5", "select ack after cycle", ak, 1);
  endtask

  initial begin
    tick(190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      report();
    end
  end

  initial begin
    bit ak, stab, sak, dak;
    int unsigned seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < MB; i++) known[i] = 1'b0;
    tick(5); rst_n = 1'b1; tick(3);
    chk(sda_oe == 1'b0 && busy == 1'b0, "R1", "reset outputs", {sda_oe, busy}, 0);

    // R1: select byte without any start is ignored
    scl_m = 1'b0; tick(Q);
    send_byte(sel_byte(1'b0, 1'b0), ak);
    chk(!ak, "R1", "ack without start", ak, 0);
    i2c_stop();

    // R2: wrong type field
    i2c_start(); send_byte(8'b1011_1000, ak); i2c_stop();
    chk(!ak, "R2", "wrong type ack", ak, 0);

    // R3: chip-enable mismatch on bits[3:2]
    i2c_start(); send_byte(8'b1010_0100, ak); i2c_stop();
    chk(!ak, "R3", "ce mismatch ack", ak, 0);

    // R2/R3: matching select acknowledged; R5: stop with no data, no cycle
    i2c_start(); send_byte(sel_byte(1'b0, 1'b1), ak); i2c_stop();
    chk(ak, "R2", "matching select ack", ak, 1);
    tick(Q);
    chk(!busy, "R5", "busy without data", busy, 0);

    // R4/R5: byte write and busy polling
    wdat[0] = 8'h5A;
    do_write(32'h123, 1, dak);
    chk(dak, "R4", "byte write data ack", dak, 1);
    chk(busy, "R5", "busy after stop", busy, 1);
    i2c_start(); send_byte(sel_byte(1'b0, 1'b0), ak); i2c_stop();
    chk(!ak, "R5", "select ack while busy", ak, 0);
    wait_ready();
    rand_read(32'h123, 1, stab, sak);
    chk(sak, "R6", "read select ack", sak, 1);
    chk(rdat[0] == ref_m[32'h123], "R6", "random read", rdat[0], ref_m[32'h123]);

    // R4: 20-byte page write from offset 10 wraps inside page 0x1F0
    for (int k = 0; k < 20; k++) wdat[k] = 8'($urandom);
    do_write(32'h1FA, 20, dak);
    chk(dak, "R4", "page write data ack", dak, 1);
    wait_ready();
    rand_read(32'h1F0, 16, stab, sak);
    for (int k = 0; k < 16; k++)
      chk(rdat[k] == ref_m[32'h1F0 + k], "R4", "page wrap byte", rdat[k], ref_m[32'h1F0 + k]);
    chk(stab, "R11", "SDA steady while SCL high", stab, 1);

    // R8: seed 0x000/0x001 then wrap-read across the top
    wdat[0] = 8'h11; wdat[1] = 8'h22;
    do_write(32'h000, 2, dak);
    wait_ready();
    rand_read(32'h1FE, 4, stab, sak);
    for (int k = 0; k < 4; k++)
      chk(rdat[k] == ref_m[seq_addr(32'h1FE, k)], "R8", "sequential wrap", rdat[k],
          ref_m[seq_addr(32'h1FE, k)]);

    // R7: counter is now 0x002; current-address reads with select A8 = 0
    wdat[0] = 8'h33; wdat[1] = 8'h44;
    do_write(32'h002, 2, dak);
    wait_ready();
    rand_read(32'h000, 2, stab, sak);
    i2c_start(); send_byte(sel_byte(1'b1, 1'b0), ak);
    recv_byte(1'b0, rdat[0], stab); i2c_stop();
    chk(rdat[0] == 8'h33, "R7", "current read", rdat[0], 8'h33);
    i2c_start(); send_byte(sel_byte(1'b1, 1'b0), ak);
    recv_byte(1'b0, rdat[0], stab);
    chk(rdat[0] == 8'h44, "R7", "second current read", rdat[0], 8'h44);

    // R9: after no-ack, further clocks see no drive
    recv_byte(1'b0, rdat[1], stab);
    chk(rdat[1] == 8'hFF, "R9", "silent after no-ack", rdat[1], 8'hFF);
    i2c_stop();
    chk(!sda_oe, "R9", "released after stop", sda_oe, 0);

    // R10: write protect
    wp = 1'b1;
    i2c_start(); send_byte(sel_byte(1'b0, 1'b1), sak); send_byte(8'h23, ak);
    chk(sak && ak, "R10", "select/address ack under wp", {sak, ak}, 3);
    send_byte(8'hC3, dak); i2c_stop();
    chk(!dak, "R10", "data ack under wp", dak, 0);
    tick(Q);
    chk(!busy, "R10", "no cycle under wp", busy, 0);
    wp = 1'b0;
    rand_read(32'h123, 1, stab, sak);
    chk(rdat[0] == 8'h5A, "R10", "array unchanged", rdat[0], 8'h5A);

    // R12: repeated start discards buffered data
    i2c_start(); send_byte(sel_byte(1'b0, 1'b1), ak); send_byte(8'hF5, ak);
    send_byte(8'h99, ak);
    i2c_start(); send_byte(sel_byte(1'b1, 1'b1), ak);
    recv_byte(1'b0, rdat[0], stab); i2c_stop();
    tick(Q);
    chk(!busy, "R12", "no cycle after restart", busy, 0);
    rand_read(32'h1F5, 1, stab, sak);
    chk(rdat[0] == ref_m[32'h1F5], "R12", "byte not committed", rdat[0], ref_m[32'h1F5]);

    // R4/R6: random page writes checked by read-back
    for (int it = 0; it < 6; it++) begin
      int a, n;
      a = int'($urandom % MB);
      n = 1 + int'($urandom % 20);
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      do_write(a, n, dak);
      chk(dak, "R4", "random write ack", dak, 1);
      wait_ready();
      rand_read(a & ~15, 16, stab, sak);
      for (int k = 0; k < 16; k++)
        if (known[(a & ~15) + k])
          chk(rdat[k] == ref_m[(a & ~15) + k], "R6", "random read-back", rdat[k],
              ref_m[(a & ~15) + k]);
    end

    done = 1'b1;
    report();
  end
endmodule